// File: doc/BRIEF.md
# Threshold-Triggered Packet Burst Reader

This block runs the read side of a small clock-crossing FIFO that carries fixed-length packets. It watches a level flag that the FIFO raises when it holds at least three of its six entries, and it answers with a consume strobe. While idle, the flag passes straight through to the strobe, so the first word of a packet is taken in the same read clock that the flag is first seen high. From then on the strobe stays high on every clock until exactly one packet of `PKT_LEN` words has been drained, whatever the flag does. After that the block waits again for the flag.

Each word is captured on the clock edge that ends a consume cycle. It is then presented on an output stream as `o_valid`, `o_data` and `o_last`. This output stream has no ready input. The upstream FIFO cannot pause in the middle of a packet, so the consumer must accept one word on every cycle in which `o_valid` is high. The consumer applies no back-pressure. A packet counter advances with each end-of-packet pulse.

A starvation monitor reports a stream that has stopped. After a packet completes, the flag may stay low for up to `STARVE_LIMIT` idle clocks. One more low clock sets a sticky error flag. Only reset clears it.

Top module: `pbr_burst_reader`

## Requirements
- R1: While `rst` is high, and on release of reset, `o_valid`, `o_last` and `starve_err` are 0, `pkt_cnt` is 0 and the block is idle.
- R2: While idle with `lvl_half` low, `rd_take` is 0.
- R3: While idle, `rd_take` equals `lvl_half` combinationally, in the same cycle, so the first word is taken in the cycle the flag is first seen high.
- R4: Once a word is taken, `rd_take` stays 1 on every following clock until `PKT_LEN` words in total have been taken, even if `lvl_half` falls in the middle of the packet.
- R5: One cycle after each cycle with `rd_take` = 1, `o_valid` is 1 and `o_data` equals the `rd_data` value present in that consume cycle. `o_valid` is 0 one cycle after any cycle with `rd_take` = 0.
- R6: After the last word of a packet, the block is idle again. If `lvl_half` is high in the very next cycle, the next packet starts in that cycle with no gap.
- R7: `o_last` is 1 together with `o_valid` for the final word of each packet only, as a one-cycle pulse.
- R8: `pkt_cnt` is incremented by one in the same cycle that `o_last` is high. It is unchanged at all other times and wraps modulo 2^`CW`.
- R9: After a packet completes, if `lvl_half` stays low for more than `STARVE_LIMIT` consecutive idle clocks, `starve_err` becomes 1. It stays 1 until reset. A gap of exactly `STARVE_LIMIT` low clocks does not set it.
- R10: Before the first packet after reset has completed, an idle wait of any length does not set `starve_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read-side clock |
| rst | input | 1 | Asynchronous active-high reset |
| lvl_half | input | 1 | FIFO level flag, high when at least half full |
| rd_data | input | W | FIFO read word at the current read position |
| rd_take | output | 1 | Consume strobe to the FIFO |
| o_valid | output | 1 | Captured word valid (no ready; cannot be stalled) |
| o_data | output | W | Captured word |
| o_last | output | 1 | Final word of a packet |
| pkt_cnt | output | CW | Completed packet count, wrapping |
| starve_err | output | 1 | Sticky starvation error |

## Verification
`rd_take` is combinational, so the bench drives its inputs 1 ns after a rising edge and reads `rd_take` 1 ns later, within the same cycle. `o_valid`, `o_data`, `o_last` and `pkt_cnt` pass through one register, so they are read 1 ns after the following rising edge. `starve_err` is also one register deep. It is read after the edge that ends the (`STARVE_LIMIT`+1)th low idle cycle, and again after the edge that ends the `STARVE_LIMIT`th low idle cycle, where it must still be 0. Every sample falls away from the active edge, so no result depends on the order in which processes run at an edge.

// File: rtl/pbr_pkg.sv
package pbr_pkg;
  typedef enum logic {
    S_WAIT  = 1'b0,
    S_DRAIN = 1'b1
  } pbr_state_t;
endpackage

// File: rtl/pbr_sequencer.sv
module pbr_sequencer #(
  parameter int PKT_LEN = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_half,
  output logic take,
  output logic last,
  output logic idle
);
  import pbr_pkg::*;
  localparam int WC_W = (PKT_LEN < 2) ? 1 : $clog2(PKT_LEN);
  localparam logic [WC_W-1:0] LAST_IDX = WC_W'(PKT_LEN - 1);

  pbr_state_t        st;
  logic [WC_W-1:0]   wcnt;

  assign idle = (st == S_WAIT);
  assign take = (st == S_DRAIN) || lvl_half;
  assign last = take && (wcnt == LAST_IDX);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      st   <= S_WAIT;
      wcnt <= '0;
    end else if (take) begin
      if (last) begin
        st   <= S_WAIT;
        wcnt <= '0;
      end else begin
        st   <= S_DRAIN;
        wcnt <= wcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pbr_capture.sv
module pbr_capture #(
  parameter int W  = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          last,
  input  logic [W-1:0]  rd_data,
  output logic          o_valid,
  output logic [W-1:0]  o_data,
  output logic          o_last,
  output logic [CW-1:0] pkt_cnt
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_last  <= 1'b0;
      o_data  <= '0;
      pkt_cnt <= '0;
    end else begin
      o_valid <= take;
      o_last  <= last;
      if (take) o_data <= rd_data;
      if (last) pkt_cnt <= pkt_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pbr_starve_mon.sv
module pbr_starve_mon #(
  parameter int STARVE_LIMIT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic idle,
  input  logic lvl_half,
  input  logic pkt_done,
  output logic starve_err
);
  localparam int GW = $clog2(STARVE_LIMIT + 1) + 1;
  localparam logic [GW-1:0] LIM = GW'(STARVE_LIMIT);

  logic          armed;
  logic [GW-1:0] gap;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      armed      <= 1'b0;
      gap        <= '0;
      starve_err <= 1'b0;
    end else if (pkt_done) begin
      armed <= 1'b1;
      gap   <= '0;
    end else if (idle && lvl_half) begin
      gap <= '0;
    end else if (idle && armed) begin
      if (gap >= LIM) starve_err <= 1'b1;
      else            gap <= gap + 1'b1;
    end
  end
endmodule

// File: rtl/pbr_burst_reader.sv
module pbr_burst_reader #(
  parameter int W            = 32,
  parameter int PKT_LEN      = 20,
  parameter int CW           = 16,
  parameter int STARVE_LIMIT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lvl_half,
  input  logic [W-1:0]  rd_data,
  output logic          rd_take,
  output logic          o_valid,
  output logic [W-1:0]  o_data,
  output logic          o_last,
  output logic [CW-1:0] pkt_cnt,
  output logic          starve_err
);
  logic pkt_last;
  logic seq_idle;

  pbr_sequencer #(.PKT_LEN(PKT_LEN)) u_seq (
    .clk(clk), .rst(rst), .lvl_half(lvl_half),
    .take(rd_take), .last(pkt_last), .idle(seq_idle)
  );

  pbr_capture #(.W(W), .CW(CW)) u_cap (
    .clk(clk), .rst(rst), .take(rd_take), .last(pkt_last),
    .rd_data(rd_data), .o_valid(o_valid), .o_data(o_data),
    .o_last(o_last), .pkt_cnt(pkt_cnt)
  );

  pbr_starve_mon #(.STARVE_LIMIT(STARVE_LIMIT)) u_mon (
    .clk(clk), .rst(rst), .idle(seq_idle), .lvl_half(lvl_half),
    .pkt_done(pkt_last), .starve_err(starve_err)
  );
endmodule

// File: rtl/pbr_checker.sv
module pbr_checker #(
  parameter int W  = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          lvl_half,
  input logic [W-1:0]  rd_data,
  input logic          rd_take,
  input logic          pkt_last,
  input logic          seq_idle,
  input logic          o_valid,
  input logic [W-1:0]  o_data,
  input logic          o_last,
  input logic [CW-1:0] pkt_cnt,
  input logic          starve_err
);
  p_idle_gate_r2: assert property (@(posedge clk) disable iff (rst)
    (seq_idle && !lvl_half) |-> !rd_take);
  p_burst_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_take && !pkt_last) |=> rd_take);
  p_valid_follows_r5: assert property (@(posedge clk) disable iff (rst)
    rd_take |=> (o_valid && o_data == $past(rd_data)));
  p_no_valid_r5: assert property (@(posedge clk) disable iff (rst)
    !rd_take |=> !o_valid);
  p_return_idle_r6: assert property (@(posedge clk) disable iff (rst)
    pkt_last |=> seq_idle);
  p_last_valid_r7: assert property (@(posedge clk) disable iff (rst)
    o_last |-> o_valid);
  p_cnt_step_r8: assert property (@(posedge clk) disable iff (rst)
    o_last |-> pkt_cnt == CW'($past(pkt_cnt) + 1'b1));
  p_cnt_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !o_last |-> $stable(pkt_cnt));
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    starve_err |=> starve_err);
endmodule

bind pbr_burst_reader pbr_checker #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .lvl_half(lvl_half), .rd_data(rd_data),
  .rd_take(rd_take), .pkt_last(pkt_last), .seq_idle(seq_idle),
  .o_valid(o_valid), .o_data(o_data), .o_last(o_last),
  .pkt_cnt(pkt_cnt), .starve_err(starve_err)
);

// File: tb/test_pbr_burst_reader.sv
module test_pbr_burst_reader;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 16;
  localparam int L   = 5;
  localparam int CW  = 3;
  localparam int LIM = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lvl_half = 1'b0;
  logic [W-1:0]  rd_data = '0;
  logic          rd_take, o_valid, o_last, starve_err;
  logic [W-1:0]  o_data;
  logic [CW-1:0] pkt_cnt;

  int n_chk = 0;
  int n_fail = 0;
  int exp_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pbr_burst_reader #(.W(W), .PKT_LEN(L), .CW(CW), .STARVE_LIMIT(LIM)) i_pbr_burst_reader (
    .clk(clk), .rst(rst), .lvl_half(lvl_half), .rd_data(rd_data),
    .rd_take(rd_take), .o_valid(o_valid), .o_data(o_data), .o_last(o_last),
    .pkt_cnt(pkt_cnt), .starve_err(starve_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // drive one cycle (1 ns after edge), sample strobe, advance past next edge
  task automatic cyc(input logic lvl, input logic [W-1:0] d, output logic took);
    lvl_half = lvl;
    rd_data  = d;
    #1 took = rd_take;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1; lvl_half = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    exp_cnt = 0;
  endtask

  // one full packet; drop_mid lowers the flag after the first word
  task automatic packet(input logic [W-1:0] base, input bit drop_mid);
    logic took;
    for (int i = 0; i < L; i++) begin
      cyc((i == 0) ? 1'b1 : !drop_mid, base + W'(i), took);
      chk((i == 0) ? "R3 first take" : "R4 hold take", {31'd0, took}, 32'd1);
      chk("R5 valid", {31'd0, o_valid}, 32'd1);
      chk("R5 data", {16'd0, o_data}, {16'd0, base + W'(i)});
      chk("R7 last", {31'd0, o_last}, (i == L-1) ? 32'd1 : 32'd0);
      if (i == L-1) exp_cnt = (exp_cnt + 1) % (1 << CW);
      chk("R8 count", {29'd0, pkt_cnt}, exp_cnt);
    end
  endtask

  task automatic gap(input int n, input string req);
    logic took;
    for (int i = 0; i < n; i++) begin
      cyc(1'b0, 16'hDEAD, took);
      chk({req, " no take"}, {31'd0, took}, 32'd0);
      chk("R5 no valid", {31'd0, o_valid}, 32'd0);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    #1;
    chk("R1 valid in reset", {31'd0, o_valid}, 32'd0);
    chk("R1 count in reset", {29'd0, pkt_cnt}, 32'd0);
    do_reset();
    chk("R1 last", {31'd0, o_last}, 32'd0);
    chk("R1 err", {31'd0, starve_err}, 32'd0);
  endtask

  task automatic t_gate_and_noarm();
    do_reset();
    gap(10, "R2");
    chk("R10 no err before first packet", {31'd0, starve_err}, 32'd0);
  endtask

  task automatic t_packet_drop();
    do_reset();
    gap(2, "R2");
    packet(16'h1000, 1'b1);
    gap(1, "R6 idle after packet");
  endtask

  task automatic t_back_to_back();
    do_reset();
    for (int p = 0; p < 9; p++) packet(16'h2000 + 16'(p * 16), 1'b0);
    chk("R8 wrap", {29'd0, pkt_cnt}, 32'd1);
    chk("R6 no err back-to-back", {31'd0, starve_err}, 32'd0);
  endtask

  task automatic t_gap_ok();
    do_reset();
    packet(16'h3000, 1'b0);
    gap(LIM, "R9");
    chk("R9 exact limit no err", {31'd0, starve_err}, 32'd0);
    packet(16'h3100, 1'b0);
    chk("R9 still clear", {31'd0, starve_err}, 32'd0);
  endtask

  task automatic t_starve();
    do_reset();
    packet(16'h4000, 1'b0);
    gap(LIM, "R9");
    chk("R9 before limit", {31'd0, starve_err}, 32'd0);
    gap(1, "R9");
    chk("R9 err set", {31'd0, starve_err}, 32'd1);
    packet(16'h4100, 1'b0);
    chk("R9 sticky", {31'd0, starve_err}, 32'd1);
    do_reset();
    chk("R1 err cleared", {31'd0, starve_err}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_gate_and_noarm();
    t_packet_drop();
    t_back_to_back();
    t_gap_ok();
    t_starve();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule